// File: doc/BRIEF.md
# Key-protected register write gate

This block is a small configuration register file whose write path is guarded by unlock keys. A plain memory-mapped bus (address, write data, write enable, read enable, registered read data) reaches three kinds of slot: data registers, per-entry lock registers and a pair of kick registers. A data register can be left unprotected, be guarded by a lock entry, or be guarded by the kick pair. Lock keys, lock targets, kick keys and the set of kick-guarded registers are all fixed by parameters.

A lock entry opens a short write window when its lock register receives the right key. The window closes by itself after `WIN` cycles. A write of zero or of a wrong key closes it at once. The kick pair stays open for as long as both kick registers hold their keys. A write that the gate refuses leaves the register untouched and raises a one-cycle violation pulse. Reads are never gated.

The bus has no valid/ready handshake and no back-pressure. Every write completes at the clock edge where `bus_we` is sampled, and every read returns its data on the next cycle.

Top module: `keygate_regs`

## Requirements
- R1: After reset, every data register and both kick registers read zero, `gate_viol` is low and every lock window is closed.
- R2: The address map is as follows. Data register r sits at address r, for r in 0..NREG-1. Lock entry e sits at address NREG+e. The kick registers sit at NREG+NLOCK and NREG+NLOCK+1. In the default configuration (NREG=8, NLOCK=4), registers 0 and 1 are unprotected and accept every write.
- R3: Writing the key of lock entry e to that entry's lock register lets writes to its target land in the 1st through WIN-th cycle after the key write (WIN=4 by default). A write in cycle WIN+1 or later is refused. In the default configuration, entries 0, 1 and 2 guard registers 4, 5 and 6 with keys 32'h5A5A0004, 32'h5A5A0005 and 32'h5A5A0006.
- R4: Writing zero to a lock register closes its window at once.
- R5: Writing a value other than the key to a lock register leaves it closed and cancels any open window.
- R6: A lock entry whose key is zero is absent: writes to its lock address open nothing and it does not guard its target. By default, entry 3 has key zero and points at register 7, which is therefore guarded only by the kick pair.
- R7: A kick-guarded register accepts writes only while kick register 0 holds 32'h13579BDF and kick register 1 holds 32'h2468ACE0. Writing zero or another value to either kick register closes access. By default, registers 2, 3 and 7 are kick-guarded. A register that has a present lock entry ignores the kick pair. The kick registers read back their stored values.
- R8: A refused write leaves the register unchanged and drives `gate_viol` high for exactly the cycle after the write. Writes to free registers, lock or kick registers, or unused addresses never raise it.
- R9: Reads are never gated. `bus_rdata` holds the addressed contents in the cycle after `bus_re`. Lock registers and unused addresses read zero.
- R10: A data register changes only on an accepted bus write to its own address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | AW (4) | Slot address |
| bus_wdata | input | DW (32) | Write data |
| bus_we | input | 1 | Write enable, one write per cycle |
| bus_re | input | 1 | Read enable |
| bus_rdata | output | DW (32) | Read data, valid the cycle after bus_re |
| gate_viol | output | 1 | One-cycle pulse after a refused data write |

## Verification
A write takes effect at the edge where it is sampled. `gate_viol` for that write is visible in the following cycle, and a read issued afterwards returns data one cycle after its own edge. The bench drives on falling edges and samples the violation flag at the falling edge right after each write. It reads every affected register back and compares the result with a bench-side model of accepted writes. The lock window is swept by placing the protected write 1 to WIN+2 cycles after the key write for each present entry, so both the last open cycle and the first closed cycle are checked.

// File: rtl/keygate_pkg.sv
package keygate_pkg;

  typedef enum logic [1:0] {
    GATE_FREE = 2'd0,
    GATE_LOCK = 2'd1,
    GATE_KICK = 2'd2
  } gate_e;

  // lock entries take precedence over the kick pair
  function automatic gate_e gate_kind(input logic has_lock, input logic kick_prot);
    if (has_lock)       return GATE_LOCK;
    else if (kick_prot) return GATE_KICK;
    else                return GATE_FREE;
  endfunction

endpackage

// File: rtl/keygate_lock.sv
module keygate_lock #(
  parameter int DW = 32,
  parameter int WIN = 4,
  parameter logic [DW-1:0] KEY = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          key_we,
  input  logic [DW-1:0] key_data,
  output logic          open
);
  localparam int CW = $clog2(WIN + 1);

  logic [CW-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
    end else if (key_we) begin
      left_q <= (KEY != '0 && key_data == KEY) ? CW'(WIN) : '0;
    end else if (left_q != '0) begin
      left_q <= left_q - 1'b1;
    end
  end

  assign open = (left_q != '0);

endmodule

// File: rtl/keygate_kick.sv
module keygate_kick #(
  parameter int DW = 32,
  parameter logic [DW-1:0] KEY0 = '0,
  parameter logic [DW-1:0] KEY1 = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we0,
  input  logic          we1,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] k0,
  output logic [DW-1:0] k1,
  output logic          open
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      k0 <= '0;
      k1 <= '0;
    end else begin
      if (we0) k0 <= wdata;
      if (we1) k1 <= wdata;
    end
  end

  assign open = (KEY0 != '0) && (k0 == KEY0) && (k1 == KEY1);

endmodule

// File: rtl/keygate_store.sv
module keygate_store #(
  parameter int DW = 32,
  parameter int NREG = 8,
  parameter int IW = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [IW-1:0]             wr_idx,
  input  logic [DW-1:0]             wdata,
  output logic [NREG-1:0][DW-1:0]   regs
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      regs <= '0;
    end else begin
      for (int r = 0; r < NREG; r++) begin
        if (wr_en && wr_idx == IW'(r)) regs[r] <= wdata;
      end
    end
  end

endmodule

// File: rtl/keygate_regs.sv
module keygate_regs
  import keygate_pkg::*;
#(
  parameter int DW = 32,
  parameter int NREG = 8,
  parameter int NLOCK = 4,
  parameter int WIN = 4,
  parameter logic [NLOCK-1:0][7:0] LOCK_TGT = {8'd7, 8'd6, 8'd5, 8'd4},
  parameter logic [NLOCK-1:0][DW-1:0] LOCK_KEY =
    {32'h0000_0000, 32'h5A5A_0006, 32'h5A5A_0005, 32'h5A5A_0004},
  parameter logic [NREG-1:0] KICK_MASK = 8'b1000_1100,
  parameter logic [DW-1:0] KICK_KEY0 = 32'h1357_9BDF,
  parameter logic [DW-1:0] KICK_KEY1 = 32'h2468_ACE0,
  localparam int AW = $clog2(NREG + NLOCK + 2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  input  logic          bus_we,
  input  logic          bus_re,
  output logic [DW-1:0] bus_rdata,
  output logic          gate_viol
);
  localparam int IW = (NREG > 1) ? $clog2(NREG) : 1;
  localparam int KICK0_A = NREG + NLOCK;
  localparam int KICK1_A = NREG + NLOCK + 1;

  logic [NREG-1:0][DW-1:0] regs;
  logic [NLOCK-1:0]        lock_open;
  logic [DW-1:0]           kick0_q, kick1_q;
  logic                    kick_open;
  logic [NREG-1:0]         allowed;
  logic                    hit_data, wr_ok, reject;
  logic [IW-1:0]           idx;

  assign hit_data = bus_we && (bus_addr < AW'(NREG));
  assign idx      = IW'(bus_addr);

  // one timer per lock entry
  for (genvar e = 0; e < NLOCK; e++) begin : g_lock
    keygate_lock #(.DW(DW), .WIN(WIN), .KEY(LOCK_KEY[e])) u_lock (
      .clk      (clk),
      .rst_n    (rst_n),
      .key_we   (bus_we && bus_addr == AW'(NREG + e)),
      .key_data (bus_wdata),
      .open     (lock_open[e])
    );
  end

  keygate_kick #(.DW(DW), .KEY0(KICK_KEY0), .KEY1(KICK_KEY1)) u_kick (
    .clk   (clk),
    .rst_n (rst_n),
    .we0   (bus_we && bus_addr == AW'(KICK0_A)),
    .we1   (bus_we && bus_addr == AW'(KICK1_A)),
    .wdata (bus_wdata),
    .k0    (kick0_q),
    .k1    (kick1_q),
    .open  (kick_open)
  );

  // per-register gate decision
  for (genvar r = 0; r < NREG; r++) begin : g_gate
    logic  has_l, ok_l;
    gate_e kind;

    always_comb begin
      has_l = 1'b0;
      ok_l  = 1'b0;
      for (int e = 0; e < NLOCK; e++) begin
        if (LOCK_KEY[e] != '0 && int'(LOCK_TGT[e]) == r) begin
          has_l = 1'b1;
          if (lock_open[e]) ok_l = 1'b1;
        end
      end
    end

    assign kind = gate_kind(has_l, KICK_MASK[r] && (KICK_KEY0 != '0));

    always_comb begin
      case (kind)
        GATE_LOCK: allowed[r] = ok_l;
        GATE_KICK: allowed[r] = kick_open;
        default:   allowed[r] = 1'b1;
      endcase
    end
  end

  assign wr_ok  = hit_data && allowed[idx];
  assign reject = hit_data && !allowed[idx];

  keygate_store #(.DW(DW), .NREG(NREG), .IW(IW)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_ok),
    .wr_idx (idx),
    .wdata  (bus_wdata),
    .regs   (regs)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_viol <= 1'b0;
      bus_rdata <= '0;
    end else begin
      gate_viol <= reject;
      if (bus_re) begin
        if (bus_addr < AW'(NREG))             bus_rdata <= regs[idx];
        else if (bus_addr == AW'(KICK0_A))    bus_rdata <= kick0_q;
        else if (bus_addr == AW'(KICK1_A))    bus_rdata <= kick1_q;
        else                                  bus_rdata <= '0;
      end
    end
  end

endmodule

// File: rtl/keygate_chk.sv
module keygate_chk #(
  parameter int DW = 32,
  parameter int NREG = 8,
  parameter int NLOCK = 4,
  parameter int AW = 4,
  parameter logic [NLOCK-1:0][DW-1:0] LOCK_KEY = '0
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [AW-1:0]           bus_addr,
  input logic [DW-1:0]           bus_wdata,
  input logic                    bus_we,
  input logic                    gate_viol,
  input logic [NREG-1:0][DW-1:0] regs,
  input logic [NLOCK-1:0]        lock_open
);
  // R8
  viol_keeps_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gate_viol |-> $stable(regs));

  // R8
  viol_after_data_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gate_viol |-> $past(bus_we && bus_addr < AW'(NREG)));

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    // R10
    change_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(regs[r]) |-> $past(bus_we && bus_addr == AW'(r)));
  end

  for (genvar e = 0; e < NLOCK; e++) begin : g_ent
    // R5
    bad_key_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == AW'(NREG + e) && bus_wdata != LOCK_KEY[e]) |=> !lock_open[e]);
  end

endmodule

bind keygate_regs keygate_chk #(
  .DW(DW), .NREG(NREG), .NLOCK(NLOCK), .AW(AW), .LOCK_KEY(LOCK_KEY)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_we    (bus_we),
  .gate_viol (gate_viol),
  .regs      (regs),
  .lock_open (lock_open)
);

// File: tb/keygate_regs_test.sv
`timescale 1ns/1ps
module keygate_regs_test;
  localparam int WIN = 4;
  localparam logic [31:0] KK0 = 32'h1357_9BDF;
  localparam logic [31:0] KK1 = 32'h2468_ACE0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic        bus_re = 1'b0;
  logic [31:0] bus_rdata;
  logic        gate_viol;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  logic [31:0] model [8];
  logic        last_viol;

  keygate_regs uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata), .gate_viol(gate_viol)
  );

  always #2 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    last_viol = gate_viol;
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_re = 1'b1; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    bus_re = 1'b0;
  endtask

  // write a data register, check the pulse, read back against the model
  task automatic wr_data(input string tag, input int r, input logic [31:0] d, input bit ok);
    logic [31:0] v;
    wr(4'(r), d);
    check({tag, " viol"}, {31'd0, last_viol}, {31'd0, !ok});
    if (ok) model[r] = d;
    rd(4'(r), v);
    check({tag, " data"}, v, model[r]);
  endtask

  task automatic wr_ctl(input string tag, input logic [3:0] a, input logic [31:0] d);
    wr(a, d);
    check({tag, " no viol"}, {31'd0, last_viol}, 32'd0);
  endtask

  initial begin
    logic [31:0] v;
    for (int i = 0; i < 8; i++) model[i] = '0;
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1 R9: reset state over the whole map
    check("R1 viol", {31'd0, gate_viol}, 32'd0);
    for (int a = 0; a < 16; a++) begin
      rd(4'(a), v);
      check($sformatf("R1 R9 read addr %0d", a), v, 32'd0);
    end

    // R2 R8: nothing unlocked, only regs 0 and 1 take writes
    for (int r = 0; r < 8; r++)
      wr_data($sformatf("R2 R8 plain reg%0d", r), r, 32'h1000 + r, r < 2);

    // R3: window sweep for each present lock entry
    for (int e = 0; e < 3; e++) begin
      for (int d = 1; d <= WIN + 2; d++) begin
        idle(WIN + 2);
        wr_ctl("R3 key", 4'(8 + e), 32'h5A5A_0004 + e);
        idle(d - 1);
        wr_data($sformatf("R3 entry%0d delay%0d", e, d), 4 + e,
                32'hA000_0000 + (e << 8) + d, d <= WIN);
      end
    end

    // R4: zero closes at once
    idle(WIN + 2);
    wr_ctl("R4 key", 4'd9, 32'h5A5A_0005);
    wr_ctl("R4 zero", 4'd9, 32'h0);
    wr_data("R4 after zero", 5, 32'hB0B0_0005, 1'b0);

    // R5: wrong key cancels an open window; wrong key alone opens nothing
    idle(WIN + 2);
    wr_ctl("R5 key", 4'd8, 32'h5A5A_0004);
    wr_ctl("R5 bad", 4'd8, 32'h5A5A_0005);
    wr_data("R5 cancelled", 4, 32'hC0C0_0004, 1'b0);
    wr_ctl("R5 bad only", 4'd10, 32'h5A5A_0005);
    wr_data("R5 bad only", 6, 32'hC0C0_0006, 1'b0);

    // R6: absent entry opens nothing; reg7 falls to the kick pair
    wr_ctl("R6 absent lock", 4'd11, 32'h5A5A_0007);
    wr_data("R6 reg7 no kick", 7, 32'hD0D0_0007, 1'b0);
    wr_ctl("R6 absent zero", 4'd11, 32'h0);
    wr_data("R6 reg7 still shut", 7, 32'hD0D1_0007, 1'b0);

    // R7: kick pair
    wr_ctl("R7 kick0", 4'd12, KK0);
    wr_data("R7 half open reg2", 2, 32'hE0E0_0002, 1'b0);
    wr_ctl("R7 kick1", 4'd13, KK1);
    wr_data("R7 open reg2", 2, 32'hE1E1_0002, 1'b1);
    wr_data("R7 open reg3", 3, 32'hE1E1_0003, 1'b1);
    wr_data("R6 R7 open reg7", 7, 32'hE1E1_0007, 1'b1);
    wr_data("R7 lock wins reg4", 4, 32'hE1E1_0004, 1'b0);
    wr_data("R7 free reg0", 0, 32'hE1E1_0000, 1'b1);
    rd(4'd12, v); check("R7 R9 kick0 read", v, KK0);
    rd(4'd13, v); check("R7 R9 kick1 read", v, KK1);
    rd(4'd8, v);  check("R9 lock reads zero", v, 32'd0);
    wr_ctl("R7 kick0 clear", 4'd12, 32'h0);
    wr_data("R7 closed reg3", 3, 32'hF0F0_0003, 1'b0);
    wr_ctl("R7 kick0 back", 4'd12, KK0);
    wr_data("R7 reopened reg3", 3, 32'hF1F1_0003, 1'b1);
    wr_ctl("R7 kick1 wrong", 4'd13, KK1 ^ 32'h1);
    wr_data("R7 wrong kick1 reg2", 2, 32'hF2F2_0002, 1'b0);

    // R8 R9: unused addresses
    wr_ctl("R8 unused 14", 4'd14, 32'hFFFF_FFFF);
    wr_ctl("R8 unused 15", 4'd15, 32'hFFFF_FFFF);
    rd(4'd14, v); check("R9 unused read", v, 32'd0);

    // R10: final readback of every data register
    for (int r = 0; r < 8; r++) begin
      rd(4'(r), v);
      check($sformatf("R10 final reg%0d", r), v, model[r]);
    end

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule